// File: doc/BRIEF.md
# Core-to-Bus Clock Ratio Enable Generator

This block runs on the fast core clock and produces a single-cycle enable that qualifies the same clock to form a slower, synchronous bus clock. The bus can run at the full core rate or at one half, one third or one quarter of it. A 3-bit select field picks the ratio. The block outputs the enable together with the divide count it is actually applying.

A new ratio is taken from the select field only while the power-mode sequencer reports that it has settled, meaning the actual mode equals the requested mode. While a mode change is in flight, the ratio already in use is held. Any mode other than full-speed operation forces a 1:1 ratio, because the bus then runs from the slow clock sources and needs no division. Whenever the applied ratio changes, the enable count restarts, so the bus never sees a shortened period.

Top module: `bus_ratio_enable_gen`

## Requirements
- R1: The select field maps to a divide count N as follows: 000 gives N=1, 001 gives N=2, 010 gives N=3 and 011 gives N=4. The output `applied_ratio` carries N-1 as a 2-bit value.
- R2: The select values 100, 101, 110 and 111 give N=1.
- R3: While `mode_normal` and `mode_stable` are both high at a clock edge, `applied_ratio` takes the decoded select value from that edge onwards.
- R4: While `mode_normal` is high and `mode_stable` is low, `applied_ratio` keeps its value, whatever the select field does.
- R5: Whenever `mode_normal` is low at a clock edge, `applied_ratio` becomes 0 (N=1), whatever `mode_stable` and the select field are.
- R6: While the applied N is 1, `bus_en` is high in every cycle.
- R7: While the applied N is greater than 1 and does not change, `bus_en` is high in exactly one cycle out of every N.
- R8: In the first cycle that shows a new `applied_ratio` value, `bus_en` is high. The next pulse then follows N cycles later.
- R9: A synchronous active-high reset sets `applied_ratio` to 0, and `bus_en` is high in the cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| ratio_sel | input | 3 | Requested core-to-bus ratio select |
| mode_stable | input | 1 | High when the actual mode equals the requested mode |
| mode_normal | input | 1 | High when the current mode is full-speed operation |
| bus_en | output | 1 | Bus clock enable, one core cycle wide |
| applied_ratio | output | 2 | Divide count in use, minus one |

## Verification
Each of the eight select codes is latched once and then held, so that the pulse spacing measured for the four legal codes can be told apart from the 1:1 fallback of the four upper codes. Directed runs toggle the select field while the stable flag is low, and drop the full-speed indicator while the flag is high. These runs separate the hold behaviour from the forced 1:1 behaviour. A long random run then changes the select, the stable flag and the mode indicator at arbitrary phases of the count. This exposes any pulse that comes too early or too late after a ratio change lands in the middle of a bus period.

// File: rtl/bus_ratio_pkg.sv
package bus_ratio_pkg;

    localparam int SEL_W = 3;
    localparam int DIV_W = 2;

    typedef enum logic [DIV_W-1:0] {
        DIV1 = 2'd0,
        DIV2 = 2'd1,
        DIV3 = 2'd2,
        DIV4 = 2'd3
    } div_e;

    function automatic div_e sel_to_div(logic [SEL_W-1:0] sel);
        div_e d;
        case (sel)
            3'b001:  d = DIV2;
            3'b010:  d = DIV3;
            3'b011:  d = DIV4;
            default: d = DIV1;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/bus_ratio_select.sv
module bus_ratio_select
    import bus_ratio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  logic             stable,
    input  logic             normal,
    output div_e             div_q,
    output logic             reload
);

    div_e div_d;

    always_comb begin
        if (!normal)
            div_d = DIV1;
        else if (stable)
            div_d = sel_to_div(sel);
        else
            div_d = div_q;
    end

    assign reload = (div_d != div_q);

    always_ff @(posedge clk) begin
        if (rst)
            div_q <= DIV1;
        else
            div_q <= div_d;
    end

endmodule

// File: rtl/bus_enable_counter.sv
module bus_enable_counter #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reload,
    input  logic [CNT_W-1:0] last,
    output logic             en
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || reload)
            cnt <= '0;
        else if (cnt == last)
            cnt <= '0;
        else
            cnt <= cnt + CNT_W'(1);
    end

    assign en = (cnt == '0);

endmodule

// File: rtl/bus_ratio_enable_gen.sv
module bus_ratio_enable_gen
    import bus_ratio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] ratio_sel,
    input  logic             mode_stable,
    input  logic             mode_normal,
    output logic             bus_en,
    output logic [DIV_W-1:0] applied_ratio
);

    div_e div_q;
    logic reload;

    bus_ratio_select u_select (
        .clk    (clk),
        .rst    (rst),
        .sel    (ratio_sel),
        .stable (mode_stable),
        .normal (mode_normal),
        .div_q  (div_q),
        .reload (reload)
    );

    bus_enable_counter #(.CNT_W(DIV_W)) u_counter (
        .clk    (clk),
        .rst    (rst),
        .reload (reload),
        .last   (div_q),
        .en     (bus_en)
    );

    assign applied_ratio = div_q;

endmodule

// File: rtl/bus_ratio_checker.sv
module bus_ratio_checker
    import bus_ratio_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [SEL_W-1:0] ratio_sel,
    input logic             mode_stable,
    input logic             mode_normal,
    input logic             bus_en,
    input logic [DIV_W-1:0] applied_ratio
);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (applied_ratio == '0 && bus_en)); // R9

    AST_FORCE_UNITY: assert property (@(posedge clk) disable iff (rst)
        !mode_normal |=> applied_ratio == '0); // R5

    AST_HOLD_UNSTABLE: assert property (@(posedge clk) disable iff (rst)
        (mode_normal && !mode_stable) |=> $stable(applied_ratio)); // R4

    AST_FOLLOW_SELECT: assert property (@(posedge clk) disable iff (rst)
        (mode_normal && mode_stable) |=>
            applied_ratio == DIV_W'(sel_to_div($past(ratio_sel)))); // R3

    AST_UNITY_ALWAYS_ON: assert property (@(posedge clk) disable iff (rst)
        applied_ratio == '0 |-> bus_en); // R6

    AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (rst)
        applied_ratio != $past(applied_ratio) |-> bus_en); // R8

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (bus_en && applied_ratio != '0) |=>
            (!bus_en || applied_ratio != $past(applied_ratio))); // R7

endmodule

bind bus_ratio_enable_gen bus_ratio_checker u_bus_ratio_checker (
    .clk           (clk),
    .rst           (rst),
    .ratio_sel     (ratio_sel),
    .mode_stable   (mode_stable),
    .mode_normal   (mode_normal),
    .bus_en        (bus_en),
    .applied_ratio (applied_ratio)
);

// File: tb/test_bus_ratio_enable_gen.sv
module test_bus_ratio_enable_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] ratio_sel = 3'd0;
    logic       mode_stable = 1'b0;
    logic       mode_normal = 1'b0;
    logic       bus_en;
    logic [1:0] applied_ratio;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    int m_app = 0;
    int m_cnt = 0;
    int m_prev_app = 0;
    bit m_rst_seen = 1'b0;

    always #10 clk = ~clk;

    bus_ratio_enable_gen i_bus_ratio_enable_gen (
        .clk           (clk),
        .rst           (rst),
        .ratio_sel     (ratio_sel),
        .mode_stable   (mode_stable),
        .mode_normal   (mode_normal),
        .bus_en        (bus_en),
        .applied_ratio (applied_ratio)
    );

    // Divide count minus one, from the requirement encoding (R1, R2)
    function automatic int expected_div(input logic [2:0] s);
        if (s[2])
            return 0;
        return int'(s[1:0]);
    endfunction

    task automatic compare(input string req, input int act, input int exp, input string what);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // One core cycle: inputs are already driven at the falling edge,
    // model advances at the rising edge, outputs checked at the next fall.
    task automatic step();
        int nxt;
        string ra;
        string re;
        @(posedge clk);
        m_prev_app = m_app;
        m_rst_seen = rst;
        if (rst) begin
            m_app = 0;
            m_cnt = 0;
        end else begin
            if (!mode_normal)
                nxt = 0;
            else if (mode_stable)
                nxt = expected_div(ratio_sel);
            else
                nxt = m_app;
            if (nxt != m_app)
                m_cnt = 0;
            else if (m_cnt == m_app)
                m_cnt = 0;
            else
                m_cnt = m_cnt + 1;
            m_app = nxt;
        end
        if (rst)                       ra = "R9";
        else if (!mode_normal)         ra = "R5";
        else if (!mode_stable)         ra = "R4";
        else if (ratio_sel[2])         ra = "R2";
        else                           ra = "R1/R3";
        @(negedge clk);
        if (m_rst_seen)                re = "R9";
        else if (m_app != m_prev_app)  re = "R8";
        else if (m_app == 0)           re = "R6";
        else                           re = "R7";
        compare(ra, int'(applied_ratio), m_app, "applied_ratio");
        compare(re, int'(bus_en), (m_cnt == 0) ? 1 : 0, "bus_en");
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);

        // R9: reset state
        @(negedge clk);
        step();
        step();
        rst = 1'b0;

        // R1, R2, R7, R6: latch each code, then hold it with the stable flag low
        for (int s = 0; s < 8; s++) begin
            mode_normal = 1'b1;
            mode_stable = 1'b1;
            ratio_sel   = 3'(s);
            step();
            mode_stable = 1'b0;
            for (int k = 0; k < 12; k++) step();
        end

        // R4: select wiggles while the stable flag is low
        mode_stable = 1'b1;
        ratio_sel   = 3'b011;
        step();
        mode_stable = 1'b0;
        for (int k = 0; k < 10; k++) begin
            ratio_sel = 3'(k);
            step();
        end

        // R5: leave full-speed mode with stable flag high and a divide select
        mode_stable = 1'b1;
        ratio_sel   = 3'b010;
        step();
        step();
        mode_normal = 1'b0;
        for (int k = 0; k < 6; k++) step();

        // R8: change ratio in the middle of a bus period
        mode_normal = 1'b1;
        ratio_sel   = 3'b011;
        step();
        step();
        ratio_sel   = 3'b001;
        for (int k = 0; k < 6; k++) step();

        // Reset in mid-run (R9)
        rst = 1'b1;
        step();
        rst = 1'b0;

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 9) == 0) ratio_sel = 3'($urandom_range(0, 7));
            mode_stable = ($urandom_range(0, 9) < 7);
            if ($urandom_range(0, 19) == 0) mode_normal = ~mode_normal;
            rst = ($urandom_range(0, 499) == 0);
            step();
        end
        rst = 1'b0;

        done = 1'b1;
        summary();
        $finish;
    end

endmodule